// File: doc/BRIEF.md
# DMA Descriptor Completion Controller

This block retires one 16-byte command descriptor of a descriptor-chained DMA channel. It is started with a one-cycle pulse once the data phase of a descriptor has ended. At that pulse it captures the descriptor's command byte and control byte, the channel status, three select registers, the remaining transfer length, the current command pointer and the descriptor's branch target. It then decides four things: whether the channel must stall, which descriptor fields to write back, where the command pointer goes next, and whether to raise an interrupt.

Each of the three decisions (stall, branch, interrupt) is driven by a 2-bit mode field in the control byte. Each mode field is checked against a masked compare of the low status half with one select register. The upper half of a select register is the mask and the lower half is the compare value. Write-back goes through a simple port: an enable, a byte offset within the descriptor and a 16-bit value. That port carries at most two writes per descriptor: the transfer-status field, then the residual-count field.

The controller is a single state machine. **IDLE** waits for `start`. **DECIDE** takes one cycle to evaluate the captured fields. It then takes one of three transitions: **to FINISH** for halting codes, **to STALL** when the wait mode fires, and **to WB_STAT** otherwise. **WB_STAT** writes transfer status and always moves **to WB_COUNT**. **WB_COUNT** writes the residual count when allowed and moves **to FINISH**. **FINISH** reports `done`, the next pointer and the interrupt pulse. **STALL** reports `done` with `stalled`. Both return **to IDLE**.

Top module: `dma_desc_completer`

## Requirements
- R1: After reset, and while `rst_n` is low, `done`, `irq`, `stalled` and `wr_en` are all 0; a reset in mid-run abandons the descriptor with no later `done`.
- R2: The command code is `cmd_byte[7:4]`; the low nibble is ignored. A code at or above CMD_STOP (default 7) is retired without any write, without an interrupt and with `next_ptr` equal to `cur_ptr`, and `done` appears in the 2nd cycle after the start edge.
- R3: The wait mode is `ctrl_byte[1:0]`. When it fires for a code below CMD_STOP, the block asserts `done` and `stalled` in the 2nd cycle after the start edge. In that case it makes no write, raises no interrupt and keeps `next_ptr` equal to `cur_ptr`.
- R4: Every mode field is decoded the same way: 00 never fires, 11 always fires, 01 fires when the condition is true, and 10 fires when it is false.
- R5: The condition for a select register S is true when `(status[15:0] & S[31:16]) == (S[15:0] & S[31:16])`. A zero mask therefore always gives true.
- R6: For a non-halting, non-stalled descriptor with `desc_writable`=1, the block drives one write in the 2nd cycle after the start edge. That write has offset 14 and data `status[15:0] | (1<<ACTIVE_BIT)` (default 0x0400). With `desc_writable`=0, no write occurs.
- R7: Only codes below CMD_STORE (default 4) with `desc_writable`=1 make a second write, in the 3rd cycle after the start edge. That write has offset 12 and data `xfer_left[15:0]`.
- R8: The branch mode is `ctrl_byte[3:2]`. When it fires for a non-halting, non-stalled descriptor, `next_ptr` equals `branch_addr`. Otherwise `next_ptr` equals `cur_ptr + 16`.
- R9: The interrupt mode is `ctrl_byte[5:4]`. When it fires for a code below CMD_STOP, `irq` is a single one-cycle pulse coincident with `done`. Otherwise `irq` stays 0.
- R10: A normal descriptor gives `done` as a one-cycle pulse in the 4th cycle after the start edge. A `start` that arrives while a descriptor is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin completion; sampled in IDLE only |
| cmd_byte | input | 8 | Descriptor byte holding the command code in its upper nibble |
| ctrl_byte | input | 8 | Descriptor control byte with the wait, branch and interrupt modes |
| status | input | 32 | Channel status; the low 16 bits are compared and written back |
| wait_sel | input | 32 | Mask (upper half) and value (lower half) for the wait condition |
| branch_sel | input | 32 | Mask and value for the branch condition |
| irq_sel | input | 32 | Mask and value for the interrupt condition |
| desc_writable | input | 1 | The descriptor memory accepts write-back |
| xfer_left | input | 32 | Remaining transfer length |
| cur_ptr | input | PTR_W | Command pointer of this descriptor |
| branch_addr | input | PTR_W | Branch target read from the descriptor |
| wr_en | output | 1 | Write-back enable |
| wr_off | output | 4 | Byte offset of the written field in the descriptor |
| wr_data | output | 16 | Written field value |
| done | output | 1 | One-cycle completion pulse |
| stalled | output | 1 | Qualifies `done`: the descriptor is held by the wait mode |
| irq | output | 1 | One-cycle interrupt pulse |
| next_ptr | output | PTR_W | Next command pointer, valid with `done` |

## Verification
The bench builds the block with its default parameters. These are a 32-bit pointer, halting code 7, store threshold 4 and the ACTIVE flag at bit 10. With them the codes 0 to 3 reach the residual-count write, codes 4 to 6 write status only, and codes 7 and 15 take the halting path. Pointer advance and branch targets can then be told apart by value. The vector table crosses every 2-bit mode with true and false conditions, and includes a zero mask and both writability values. Directed runs add a `start` pulse while busy and a reset in the middle of a write-back.

// File: rtl/desc_cmpl_pkg.sv
package desc_cmpl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_WB_STAT,
        ST_WB_COUNT,
        ST_FINISH,
        ST_STALL
    } cmpl_state_t;

    typedef logic [1:0] mode_t;

    localparam mode_t MODE_NEVER  = 2'b00;
    localparam mode_t MODE_IF_SET = 2'b01;
    localparam mode_t MODE_IF_CLR = 2'b10;
    localparam mode_t MODE_ALWAYS = 2'b11;

    localparam int NUM_DECISIONS = 3;
    localparam int DEC_WAIT   = 0;
    localparam int DEC_BRANCH = 1;
    localparam int DEC_IRQ    = 2;
endpackage

// File: rtl/desc_mode_eval.sv
module desc_mode_eval
    import desc_cmpl_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0]   stat_lo,
    input  logic [2*HALF_W-1:0] sel,
    input  mode_t               mode,
    output logic                fire
);
    logic [HALF_W-1:0] mask;
    logic              match;

    assign mask  = sel[2*HALF_W-1:HALF_W];
    assign match = (stat_lo & mask) == (sel[HALF_W-1:0] & mask);

    always_comb begin
        unique case (mode)
            MODE_NEVER:  fire = 1'b0;
            MODE_IF_SET: fire = match;
            MODE_IF_CLR: fire = !match;
            MODE_ALWAYS: fire = 1'b1;
            default:     fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_desc_completer.sv
module dma_desc_completer
    import desc_cmpl_pkg::*;
#(
    parameter int PTR_W      = 32,
    parameter int CMD_STOP   = 7,
    parameter int CMD_STORE  = 4,
    parameter int ACTIVE_BIT = 10,
    parameter int DESC_BYTES = 16,
    parameter int OFF_STAT   = 14,
    parameter int OFF_COUNT  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       cmd_byte,
    input  logic [7:0]       ctrl_byte,
    input  logic [31:0]      status,
    input  logic [31:0]      wait_sel,
    input  logic [31:0]      branch_sel,
    input  logic [31:0]      irq_sel,
    input  logic             desc_writable,
    input  logic [31:0]      xfer_left,
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic [PTR_W-1:0] branch_addr,
    output logic             wr_en,
    output logic [3:0]       wr_off,
    output logic [15:0]      wr_data,
    output logic             done,
    output logic             stalled,
    output logic             irq,
    output logic [PTR_W-1:0] next_ptr
);
    localparam int HALF_W = 16;
    localparam logic [3:0] STOP_C  = 4'(CMD_STOP);
    localparam logic [3:0] STORE_C = 4'(CMD_STORE);
    localparam logic [HALF_W-1:0] ACTIVE_MASK = HALF_W'(1) << ACTIVE_BIT;
    localparam logic [PTR_W-1:0]  STEP = PTR_W'(DESC_BYTES);

    cmpl_state_t state, state_nx;

    logic [3:0]        code_q;
    logic [5:0]        modes_q;
    logic [HALF_W-1:0] stat_q;
    logic [HALF_W-1:0] len_q;
    logic              wrok_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  br_q;
    logic [31:0]       sel_q [NUM_DECISIONS];
    logic [NUM_DECISIONS-1:0] fires;
    logic              live_cmd;

    logic unused_bits;
    assign unused_bits = ^{cmd_byte[3:0], ctrl_byte[7:6], status[31:16], xfer_left[31:16]};

    assign live_cmd = code_q < STOP_C;

    // capture the descriptor context on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            modes_q <= '0;
            stat_q  <= '0;
            len_q   <= '0;
            wrok_q  <= 1'b0;
            ptr_q   <= '0;
            br_q    <= '0;
            for (int i = 0; i < NUM_DECISIONS; i++) sel_q[i] <= '0;
        end else if (state == ST_IDLE && start) begin
            code_q  <= cmd_byte[7:4];
            modes_q <= ctrl_byte[5:0];
            stat_q  <= status[HALF_W-1:0];
            len_q   <= xfer_left[HALF_W-1:0];
            wrok_q  <= desc_writable;
            ptr_q   <= cur_ptr;
            br_q    <= branch_addr;
            sel_q[DEC_WAIT]   <= wait_sel;
            sel_q[DEC_BRANCH] <= branch_sel;
            sel_q[DEC_IRQ]    <= irq_sel;
        end
    end

    // one evaluator per decision; mode field g sits at control bits 2g+1:2g
    for (genvar g = 0; g < NUM_DECISIONS; g++) begin : g_eval
        desc_mode_eval #(.HALF_W(HALF_W)) u_eval (
            .stat_lo (stat_q),
            .sel     (sel_q[g]),
            .mode    (modes_q[2*g+1:2*g]),
            .fire    (fires[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_DECIDE;
            ST_DECIDE: begin
                if (!live_cmd)             state_nx = ST_FINISH;
                else if (fires[DEC_WAIT])  state_nx = ST_STALL;
                else                       state_nx = ST_WB_STAT;
            end
            ST_WB_STAT:  state_nx = ST_WB_COUNT;
            ST_WB_COUNT: state_nx = ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            ST_STALL:    state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        wr_off   = 4'(OFF_STAT);
        wr_data  = '0;
        done     = 1'b0;
        stalled  = 1'b0;
        irq      = 1'b0;
        next_ptr = ptr_q;
        unique case (state)
            ST_IDLE, ST_DECIDE: ;
            ST_WB_STAT: begin
                wr_en   = wrok_q;
                wr_off  = 4'(OFF_STAT);
                wr_data = stat_q | ACTIVE_MASK;
            end
            ST_WB_COUNT: begin
                wr_en   = wrok_q && (code_q < STORE_C);
                wr_off  = 4'(OFF_COUNT);
                wr_data = len_q;
            end
            ST_FINISH: begin
                done = 1'b1;
                irq  = live_cmd && fires[DEC_IRQ];
                if (live_cmd)
                    next_ptr = fires[DEC_BRANCH] ? br_q : ptr_q + STEP;
            end
            ST_STALL: begin
                done    = 1'b1;
                stalled = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/desc_cmpl_checker.sv
module desc_cmpl_checker #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_off,
    input logic             done,
    input logic             stalled,
    input logic             irq,
    input logic [PTR_W-1:0] next_ptr,
    input logic [PTR_W-1:0] cur_ptr
);
    logic unused_chk;
    assign unused_chk = ^{next_ptr, cur_ptr};

    // R9: the interrupt pulse rides on done and lasts one cycle
    p_irq_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: done is a one-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a stalled descriptor writes nothing and raises nothing
    p_stall_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (done && !irq && !wr_en));

    // R7: the residual count write directly follows a status write cycle
    p_count_after_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == 4'd12) |-> $past(wr_en && wr_off == 4'd14));

    // R6: write-back only targets the two descriptor fields
    p_offsets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_off == 4'd14 || wr_off == 4'd12));

    // R1: a write never coincides with completion
    p_no_write_at_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);
endmodule

bind dma_desc_completer desc_cmpl_checker #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_off   (wr_off),
    .done     (done),
    .stalled  (stalled),
    .irq      (irq),
    .next_ptr (next_ptr),
    .cur_ptr  (cur_ptr)
);

// File: tb/dma_desc_completer_test.sv
`timescale 1ns/1ps
module dma_desc_completer_test;
    localparam int PTR_W = 32;
    localparam logic [31:0] PTR0 = 32'h0000_1000;
    localparam logic [31:0] BRA  = 32'h0000_8000;
    localparam logic [31:0] LEN  = 32'h0001_0ABC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cmd_byte = '0, ctrl_byte = '0;
    logic [31:0] status = '0, wait_sel = '0, branch_sel = '0, irq_sel = '0;
    logic desc_writable = 1'b0;
    logic [31:0] xfer_left = LEN;
    logic [PTR_W-1:0] cur_ptr = PTR0, branch_addr = BRA;
    logic wr_en, done, stalled, irq;
    logic [3:0] wr_off;
    logic [15:0] wr_data;
    logic [PTR_W-1:0] next_ptr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_desc_completer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_byte(cmd_byte),
        .ctrl_byte(ctrl_byte), .status(status), .wait_sel(wait_sel),
        .branch_sel(branch_sel), .irq_sel(irq_sel), .desc_writable(desc_writable),
        .xfer_left(xfer_left), .cur_ptr(cur_ptr), .branch_addr(branch_addr),
        .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data), .done(done),
        .stalled(stalled), .irq(irq), .next_ptr(next_ptr)
    );

    // kind: 0 normal, 1 stalled by wait mode, 2 halting code
    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  ctrl;
        logic [15:0] stat;
        logic [31:0] wsel;
        logic [31:0] bsel;
        logic [31:0] isel;
        logic        wr;
        logic [1:0]  kind;
        logic        cnt;
        logic        br;
        logic        irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        //   cmd    ctrl   stat      wsel          bsel          isel        wr kind cnt br irq
        '{8'h00, 8'h00, 16'h0080, 32'h0,        32'h0,        32'h0,        1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
        '{8'h20, 8'h0C, 16'h0000, 32'h0,        32'h0,        32'h0,        1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        '{8'h40, 8'h30, 16'h0001, 32'h0,        32'h0,        32'h0,        1'b1, 2'd0, 1'b0, 1'b0, 1'b1},
        '{8'h30, 8'h04, 16'h0013, 32'h0,        32'h00FF0013, 32'h0,        1'b1, 2'd0, 1'b1, 1'b1, 1'b0},
        '{8'h30, 8'h04, 16'h0012, 32'h0,        32'h00FF0013, 32'h0,        1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
        '{8'h30, 8'h08, 16'h0012, 32'h0,        32'h00FF0013, 32'h0,        1'b1, 2'd0, 1'b1, 1'b1, 1'b0},
        '{8'h10, 8'h20, 16'h0012, 32'h0,        32'h0,        32'h000F0002, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
        '{8'h10, 8'h10, 16'h0012, 32'h0,        32'h0,        32'h000F0002, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1},
        '{8'h00, 8'h03, 16'h0000, 32'h0,        32'h0,        32'h0,        1'b1, 2'd1, 1'b0, 1'b0, 1'b0},
        '{8'h00, 8'h01, 16'h0001, 32'h00010001, 32'h0,        32'h0,        1'b1, 2'd1, 1'b0, 1'b0, 1'b0},
        '{8'h10, 8'h01, 16'h0000, 32'h00010001, 32'h0,        32'h0,        1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
        '{8'h10, 8'h32, 16'h0000, 32'h00010001, 32'h0,        32'h0,        1'b1, 2'd1, 1'b0, 1'b0, 1'b0},
        '{8'h70, 8'h3F, 16'h0000, 32'h0,        32'h0,        32'h0,        1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
        '{8'hF0, 8'h30, 16'h0000, 32'h0,        32'h0,        32'h0,        1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
        '{8'h20, 8'h04, 16'h1234, 32'h0,        32'h0000FFFF, 32'h0,        1'b1, 2'd0, 1'b1, 1'b1, 1'b0},
        '{8'h3F, 8'h00, 16'h0002, 32'h0,        32'h0,        32'h0,        1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
        '{8'h60, 8'h3C, 16'h0100, 32'h0,        32'h0,        32'h0,        1'b1, 2'd0, 1'b0, 1'b1, 1'b1},
        '{8'h50, 8'h1C, 16'h0000, 32'h0,        32'h0,        32'h00010001, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int done_k = 0, irq_n = 0, stat_k = 0, cnt_k = 0, stall_n = 0;
        logic [15:0] stat_d = '0, cnt_d = '0;
        logic [PTR_W-1:0] ptr = '0;
        int exp_done;
        logic [PTR_W-1:0] exp_ptr;
        @(negedge clk);
        cmd_byte = v.cmd; ctrl_byte = v.ctrl; status = {16'hA5A5, v.stat};
        wait_sel = v.wsel; branch_sel = v.bsel; irq_sel = v.isel;
        desc_writable = v.wr; start = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin done_k = k; ptr = next_ptr; end
            if (irq) irq_n++;
            if (stalled) stall_n++;
            if (wr_en && wr_off == 4'd14) begin stat_k = k; stat_d = wr_data; end
            if (wr_en && wr_off == 4'd12) begin cnt_k = k; cnt_d = wr_data; end
        end
        exp_done = (v.kind == 2'd0) ? 4 : 2;
        exp_ptr  = (v.kind != 2'd0) ? PTR0 : (v.br ? BRA : PTR0 + 32'd16);
        chk(done_k == exp_done, (v.kind == 2'd2) ? "R2" : "R10", "done cycle", done_k, exp_done);
        chk(stall_n == ((v.kind == 2'd1) ? 1 : 0), "R3", "stalled", stall_n, v.kind == 2'd1);
        chk(irq_n == (v.irq ? 1 : 0), "R9", "irq pulses", irq_n, v.irq);
        if (v.kind == 2'd0 && v.wr) begin
            chk(stat_k == 2, "R6", "status write cycle", stat_k, 2);
            chk(stat_d == (v.stat | 16'h0400), "R6", "status data", stat_d, v.stat | 16'h0400);
        end else
            chk(stat_k == 0, "R6", "no status write", stat_k, 0);
        if (v.cnt) begin
            chk(cnt_k == 3, "R7", "count write cycle", cnt_k, 3);
            chk(cnt_d == LEN[15:0], "R7", "count data", cnt_d, LEN[15:0]);
        end else
            chk(cnt_k == 0, "R7", "no count write", cnt_k, 0);
        chk(ptr == exp_ptr, "R8", "next pointer", ptr, exp_ptr);
    endtask

    initial begin
        #500_000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: outputs idle during and after reset
        chk(!done && !irq && !wr_en && !stalled, "R1", "outputs in reset",
            {done, irq, wr_en, stalled}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !irq && !wr_en && !stalled, "R1", "outputs after reset",
            {done, irq, wr_en, stalled}, 0);

        // R4 R5: vector table covering all mode encodings and compares
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: a start while busy is ignored
        @(negedge clk);
        cmd_byte = 8'h00; ctrl_byte = 8'h00; status = '0; desc_writable = 1'b1;
        wait_sel = '0; branch_sel = '0; irq_sel = '0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        if (done) n++;
        for (int k = 0; k < 8; k++) begin @(negedge clk); if (done) n++; end
        chk(n == 1, "R10", "done count with busy start", n, 1);

        // R1: reset in the middle of a write-back abandons the descriptor
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!wr_en && !done, "R1", "outputs in mid-run reset", {wr_en, done}, 0);
        rst_n = 1'b1;
        n = 0;
        for (int k = 0; k < 6; k++) begin @(negedge clk); if (done || wr_en) n++; end
        chk(n == 0, "R1", "activity after mid-run reset", n, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule